// File: doc/BRIEF.md
# Video RAM Access Arbiter

This block steers the address and data paths of a single-port video display RAM that two masters share: a CPU and the display refresh address generator. Outside the CPU's video window, the refresh address from the display controller feeds the RAM. As soon as the CPU address falls inside the window and the CPU's select qualifier is high, the RAM address switches to the CPU address with no clock delay. The CPU is never held off: there is no wait state and no reserved slot, and an occasional display glitch is accepted.

The block also drives a bidirectional data buffer between the CPU data bus and the RAM data pins. It has one enable for each direction, and each enable is gated by the CPU select and by the phase-2 half of the CPU cycle. It also drives the RAM write strobe. A CPU access that falls on the same clock as the character serializer's load strobe, while the display is active, is reported on a registered collision flag. The same coincidence during blanking is not reported, because nothing is visible then.

Top module: `vram_access_mux`

## Requirements
- R1: While the CPU owns the RAM, `ram_addr_o` equals the CPU address minus `WIN_BASE` (its low `RAM_AW` bits) in the same cycle, with no register in the path. With the defaults, CPU address 0xD123 gives RAM address 0x123.
- R2: While the CPU does not own the RAM, `ram_addr_o` equals `rfsh_addr_i` in the same cycle.
- R3: With `EXT_DECODE`=0, the CPU owns the RAM when both of these hold: `cpu_addr_i` lies in [`WIN_BASE`, `WIN_BASE`+2^`RAM_AW`-1], and `cpu_vsel_i` is 1. With the defaults the window is 0xD000 to 0xD7FF. `cpu_owns_o` shows ownership.
- R4: A buffer enable (`buf_a2b_o` or `buf_b2a_o`) can be 1 only while the CPU owns the RAM and `cpu_ph2_i` is 1.
- R5: During an enabled transfer, `cpu_rw_i`=1 (read) sets `buf_b2a_o` (RAM to CPU) and `cpu_rw_i`=0 (write) sets `buf_a2b_o` (CPU to RAM).
- R6: `buf_a2b_o` and `buf_b2a_o` are never 1 at the same time.
- R7: `ram_we_o` is 1 exactly when the CPU owns the RAM, `cpu_rw_i`=0 and `cpu_ph2_i`=1.
- R8: `collide_o` is 1 in the cycle after a clock edge at which `load_stb_i`, `disp_en_i` and CPU ownership are all 1. Otherwise it is 0.
- R9: A coincidence of CPU ownership and `load_stb_i` while `disp_en_i`=0 (blanking) does not set `collide_o`.
- R10: `rst` is synchronous and active high. It holds `collide_o` at 0, including over an edge at which the collision condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the display character timing |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | CPU_AW | CPU address bus |
| cpu_rw_i | input | 1 | CPU direction, 1 = read, 0 = write |
| cpu_ph2_i | input | 1 | CPU phase-2 clock level |
| cpu_vsel_i | input | 1 | Decoded video select or valid qualifier from the CPU side |
| rfsh_addr_i | input | RAM_AW | Refresh address from the display controller |
| load_stb_i | input | 1 | Serializer load strobe |
| disp_en_i | input | 1 | Delayed display enable, 0 during blanking |
| ram_addr_o | output | RAM_AW | Address to the video RAM |
| ram_we_o | output | 1 | Video RAM write strobe, active high |
| buf_a2b_o | output | 1 | Buffer enable, CPU bus to RAM |
| buf_b2a_o | output | 1 | Buffer enable, RAM to CPU bus |
| cpu_owns_o | output | 1 | CPU currently owns the RAM |
| collide_o | output | 1 | Visible-collision flag, registered |

## Verification
The address, write-strobe, buffer-enable and ownership outputs are combinational, so each is due in the cycle its inputs change. The bench drives each vector on the falling edge and samples these outputs 1 ns later, before any rising edge. The collision flag is due one rising edge after its cause, so the bench samples it 1 ns after the next rising edge and before it drives the next vector. That window is narrow enough that a flag held for two cycles, or one that appears a cycle late, is caught.

// File: rtl/vram_mux_pkg.sv
package vram_mux_pkg;

  // Control word for the data buffer and the RAM write strobe
  typedef struct packed {
    logic we;
    logic a2b;
    logic b2a;
  } vbuf_ctl_t;

  localparam vbuf_ctl_t VBUF_IDLE = '{we: 1'b0, a2b: 1'b0, b2a: 1'b0};

endpackage

// File: rtl/vram_sel_decode.sv
module vram_sel_decode #(
  parameter int                CPU_AW     = 16,
  parameter int                RAM_AW     = 11,
  parameter logic [CPU_AW-1:0] WIN_BASE   = 16'hD000,
  parameter bit                EXT_DECODE = 1'b0
) (
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              cpu_vsel_i,
  output logic              owns_o
);

  localparam int TAG_W = CPU_AW - RAM_AW;

  initial begin
    // base must be aligned to the window size so the low bits are the offset
    base_align_chk: assert (WIN_BASE[RAM_AW-1:0] == '0);
  end

  generate
    if (EXT_DECODE) begin : g_ext
      logic [CPU_AW-1:0] unused_addr;
      assign unused_addr = cpu_addr_i;
      assign owns_o = cpu_vsel_i;
    end else begin : g_int
      logic [TAG_W-1:0] tag;
      logic             hit;
      assign tag    = cpu_addr_i[CPU_AW-1:RAM_AW];
      assign hit    = (tag == WIN_BASE[CPU_AW-1:RAM_AW]);
      assign owns_o = hit & cpu_vsel_i;
    end
  endgenerate

endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux #(
  parameter int CPU_AW = 16,
  parameter int RAM_AW = 11
) (
  input  logic              owns_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [RAM_AW-1:0] rfsh_addr_i,
  output logic [RAM_AW-1:0] ram_addr_o
);

  logic [RAM_AW-1:0] cpu_off;
  assign cpu_off = cpu_addr_i[RAM_AW-1:0];

  always_comb begin
    if (owns_i) ram_addr_o = cpu_off;
    else        ram_addr_o = rfsh_addr_i;
  end

endmodule

// File: rtl/vram_buf_ctl.sv
module vram_buf_ctl
  import vram_mux_pkg::*;
(
  input  logic      owns_i,
  input  logic      cpu_rw_i,
  input  logic      cpu_ph2_i,
  output vbuf_ctl_t ctl_o
);

  logic xfer;
  assign xfer = owns_i & cpu_ph2_i;

  always_comb begin
    ctl_o = VBUF_IDLE;
    if (xfer) begin
      if (cpu_rw_i) begin
        ctl_o.b2a = 1'b1;
      end else begin
        ctl_o.a2b = 1'b1;
        ctl_o.we  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vram_collide_det.sv
module vram_collide_det (
  input  logic clk,
  input  logic rst,
  input  logic owns_i,
  input  logic load_stb_i,
  input  logic disp_en_i,
  output logic collide_o
);

  logic hit_now;
  assign hit_now = owns_i & load_stb_i & disp_en_i;

  always_ff @(posedge clk) begin
    if (rst) collide_o <= 1'b0;
    else     collide_o <= hit_now;
  end

endmodule

// File: rtl/vram_access_mux.sv
module vram_access_mux
  import vram_mux_pkg::*;
#(
  parameter int                CPU_AW     = 16,
  parameter int                RAM_AW     = 11,
  parameter logic [CPU_AW-1:0] WIN_BASE   = 16'hD000,
  parameter bit                EXT_DECODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              cpu_rw_i,
  input  logic              cpu_ph2_i,
  input  logic              cpu_vsel_i,
  input  logic [RAM_AW-1:0] rfsh_addr_i,
  input  logic              load_stb_i,
  input  logic              disp_en_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              buf_a2b_o,
  output logic              buf_b2a_o,
  output logic              cpu_owns_o,
  output logic              collide_o
);

  logic      owns;
  vbuf_ctl_t ctl;

  vram_sel_decode #(
    .CPU_AW(CPU_AW), .RAM_AW(RAM_AW), .WIN_BASE(WIN_BASE), .EXT_DECODE(EXT_DECODE)
  ) u_dec (
    .cpu_addr_i(cpu_addr_i),
    .cpu_vsel_i(cpu_vsel_i),
    .owns_o    (owns)
  );

  vram_addr_mux #(.CPU_AW(CPU_AW), .RAM_AW(RAM_AW)) u_mux (
    .owns_i     (owns),
    .cpu_addr_i (cpu_addr_i),
    .rfsh_addr_i(rfsh_addr_i),
    .ram_addr_o (ram_addr_o)
  );

  vram_buf_ctl u_buf (
    .owns_i   (owns),
    .cpu_rw_i (cpu_rw_i),
    .cpu_ph2_i(cpu_ph2_i),
    .ctl_o    (ctl)
  );

  vram_collide_det u_col (
    .clk       (clk),
    .rst       (rst),
    .owns_i    (owns),
    .load_stb_i(load_stb_i),
    .disp_en_i (disp_en_i),
    .collide_o (collide_o)
  );

  assign ram_we_o   = ctl.we;
  assign buf_a2b_o  = ctl.a2b;
  assign buf_b2a_o  = ctl.b2a;
  assign cpu_owns_o = owns;

  // R1
  cpu_addr_route_chk: assert property (@(posedge clk) disable iff (rst)
    owns |-> (ram_addr_o == cpu_addr_i[RAM_AW-1:0]));

  // R2
  rfsh_addr_route_chk: assert property (@(posedge clk) disable iff (rst)
    !owns |-> (ram_addr_o == rfsh_addr_i));

  // R4
  buf_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_a2b_o || buf_b2a_o) |-> (owns && cpu_ph2_i));

  // R5
  buf_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (owns && cpu_ph2_i) |-> (buf_b2a_o == cpu_rw_i));

  // R6
  buf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({buf_a2b_o, buf_b2a_o}) <= 1);

  // R7
  we_match_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> (buf_a2b_o && !cpu_rw_i));

  // R8
  collide_cause_chk: assert property (@(posedge clk) disable iff (rst)
    collide_o |-> $past(owns && load_stb_i && disp_en_i));

  // R9
  blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !disp_en_i |=> !collide_o);

endmodule

// File: tb/sim_vram_access_mux.sv
module sim_vram_access_mux;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr_i;
  logic        cpu_rw_i, cpu_ph2_i, cpu_vsel_i;
  logic [10:0] rfsh_addr_i;
  logic        load_stb_i, disp_en_i;
  logic [10:0] ram_addr_o;
  logic        ram_we_o, buf_a2b_o, buf_b2a_o, cpu_owns_o, collide_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vram_access_mux u0 (
    .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr_i), .cpu_rw_i(cpu_rw_i),
    .cpu_ph2_i(cpu_ph2_i), .cpu_vsel_i(cpu_vsel_i), .rfsh_addr_i(rfsh_addr_i),
    .load_stb_i(load_stb_i), .disp_en_i(disp_en_i), .ram_addr_o(ram_addr_o),
    .ram_we_o(ram_we_o), .buf_a2b_o(buf_a2b_o), .buf_b2a_o(buf_b2a_o),
    .cpu_owns_o(cpu_owns_o), .collide_o(collide_o)
  );

  typedef struct packed {
    logic [15:0] a;
    logic        rw, ph2, vs;
    logic [10:0] rf;
    logic        ld, de;
    logic [10:0] ea;
    logic        own, we, a2b, b2a, col;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 1'b1, 1'b1, 1'b1, 11'h055, 1'b0, 1'b1, 11'h055, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'hD123, 1'b1, 1'b1, 1'b1, 11'h055, 1'b0, 1'b1, 11'h123, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'hD123, 1'b0, 1'b1, 1'b1, 11'h055, 1'b0, 1'b1, 11'h123, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'hD123, 1'b0, 1'b0, 1'b1, 11'h055, 1'b0, 1'b1, 11'h123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'hD7FF, 1'b1, 1'b0, 1'b1, 11'h3AA, 1'b1, 1'b1, 11'h7FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'hD800, 1'b0, 1'b1, 1'b1, 11'h3AA, 1'b1, 1'b1, 11'h3AA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'hCFFF, 1'b0, 1'b1, 1'b1, 11'h001, 1'b0, 1'b1, 11'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'hD000, 1'b0, 1'b1, 1'b0, 11'h001, 1'b1, 1'b1, 11'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'hD000, 1'b1, 1'b1, 1'b1, 11'h700, 1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'hD400, 1'b0, 1'b1, 1'b1, 11'h700, 1'b1, 1'b1, 11'h400, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{16'hD400, 1'b1, 1'b1, 1'b1, 11'h7FF, 1'b0, 1'b1, 11'h400, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cpu_addr_i  = v.a;
    cpu_rw_i    = v.rw;
    cpu_ph2_i   = v.ph2;
    cpu_vsel_i  = v.vs;
    rfsh_addr_i = v.rf;
    load_stb_i  = v.ld;
    disp_en_i   = v.de;
  endtask

  initial begin
    #40000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(VEC[0]);
    // R10: collision condition present while reset is held
    @(negedge clk);
    drive(VEC[9]);
    @(posedge clk); #1;
    chk("R10 collide held low in reset", collide_o, 1'b0);
    @(negedge clk);
    drive(VEC[0]);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R10 collide low after reset", collide_o, 1'b0);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      chk($sformatf("R1/R2 ram_addr vec%0d", i), ram_addr_o, VEC[i].ea);
      chk($sformatf("R3 owns vec%0d", i), cpu_owns_o, VEC[i].own);
      chk($sformatf("R7 we vec%0d", i), ram_we_o, VEC[i].we);
      chk($sformatf("R4/R5 a2b vec%0d", i), buf_a2b_o, VEC[i].a2b);
      chk($sformatf("R4/R5 b2a vec%0d", i), buf_b2a_o, VEC[i].b2a);
      chk($sformatf("R6 exclusive vec%0d", i), buf_a2b_o & buf_b2a_o, 1'b0);
      @(posedge clk); #1;
      chk($sformatf("R8/R9 collide vec%0d", i), collide_o, VEC[i].col);
    end

    // R8: flag lasts one cycle once the strobe drops
    @(negedge clk);
    drive(VEC[4]);
    @(posedge clk); #1;
    chk("R8 collide set", collide_o, 1'b1);
    @(negedge clk);
    drive(VEC[3]);
    @(posedge clk); #1;
    chk("R8 collide clears next cycle", collide_o, 1'b0);

    // R9: blanking with strobe and CPU read in progress
    @(negedge clk);
    drive(VEC[8]);
    @(posedge clk); #1;
    chk("R9 blank no collide", collide_o, 1'b0);

    // R2: refresh address passes through changes while CPU is outside window
    @(negedge clk);
    drive(VEC[6]);
    rfsh_addr_i = 11'h5A5;
    #1;
    chk("R2 refresh follows", ram_addr_o, 11'h5A5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule